// File: doc/BRIEF.md
# Single-Step Register Shifter with Sign-Change Flag

This block is a registered one-position shifter for a word of parameterizable width. On each clock edge where its strobe is high, it takes the presented data word, shifts it one place in the selected direction, and captures the result. It offers three shift families. Logical shifts fill the vacated end from a serial input. Rotates wrap the departing bit around to the opposite end. Arithmetic shifts treat the word as a two's-complement number.

Every shift also records the bit that left the word. An arithmetic left shift additionally records whether the sign of the value flipped, which is a signed overflow. Any other shift clears that flag. The two unused operation codes leave the word and both flags as they are, as does a low strobe. A synchronous reset clears the word and both flags.

Top module: `shift_unit`

## Requirements
- R1: With `rst` high at a clock edge, `dout`, `out_bit` and `ovf` are all 0 after that edge.
- R2: At an edge with `rst` low and `shift_en` low, `dout`, `out_bit` and `ovf` keep their values, whatever the other inputs are.
- R3: Logical shifts. Code 3'b000 gives `dout = {din[W-2:0], ser_in}` and `out_bit = din[W-1]`. Code 3'b001 gives `dout = {ser_in, din[W-1:1]}` and `out_bit = din[0]`. Driving `ser_in` low gives the plain zero-fill shift.
- R4: Rotates. Code 3'b010 gives `dout = {din[W-2:0], din[W-1]}` and `out_bit = din[W-1]`. Code 3'b011 gives `dout = {din[0], din[W-1:1]}` and `out_bit = din[0]`.
- R5: Arithmetic left. Code 3'b100 gives `dout = {din[W-2:0], 1'b0}`, `out_bit = din[W-1]` and `ovf = din[W-1] ^ din[W-2]`.
- R6: Arithmetic right. Code 3'b101 gives `dout = {din[W-1], din[W-1:1]}`, so the sign bit is kept, and `out_bit = din[0]`.
- R7: A strobed shift with any of the codes 3'b000, 3'b001, 3'b010, 3'b011 or 3'b101 leaves `ovf` at 0.
- R8: A strobed edge with code 3'b110 or 3'b111 leaves `dout`, `out_bit` and `ovf` unchanged.
- R9: `ser_in` has no effect on rotates or arithmetic shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Strobe; the state updates only on edges where it is high |
| shift_op | input | 3 | Shift type code |
| ser_in | input | 1 | Bit entered at the vacated end by logical shifts |
| din | input | WIDTH | Word to be shifted |
| dout | output | WIDTH | Registered shifted word |
| out_bit | output | 1 | Registered bit that left the word on the last shift |
| ovf | output | 1 | Registered sign-change flag of the last arithmetic left shift |

## Verification
The hardest case to reach from the ports is a set `ovf` that must then survive edges that do not shift. The bench first raises the flag with an arithmetic left shift of a value whose two top bits differ. Before any clearing shift, it then applies a low strobe and a strobed unused code, each with changed data, and checks that the flag and the word are still held. The bench also covers all four combinations of the two top bits for the arithmetic left shift, and it drives `ser_in` high during rotates and arithmetic shifts to show that the bit is ignored there.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

    typedef enum logic [2:0] {
        OP_LSL  = 3'b000,
        OP_LSR  = 3'b001,
        OP_ROL  = 3'b010,
        OP_ROR  = 3'b011,
        OP_ASL  = 3'b100,
        OP_ASR  = 3'b101,
        OP_RSV6 = 3'b110,
        OP_RSV7 = 3'b111
    } shift_op_e;

    // Codes 0..5 move the word; bit 0 of those codes selects rightward.
    function automatic logic op_moves(input logic [2:0] code);
        return (code <= 3'b101);
    endfunction

endpackage

// File: rtl/shift_datapath.sv
module shift_datapath
    import shift_unit_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [2:0]       op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] result,
    output logic             exit_bit
);
    localparam int MSB = WIDTH - 1;

    logic go_right;
    logic fill_lo;
    logic fill_hi;

    assign go_right = op[0];

    // Bit entering at position 0 on a left move.
    always_comb begin
        unique case (shift_op_e'(op))
            OP_LSL:  fill_lo = ser_in;
            OP_ROL:  fill_lo = din[MSB];
            default: fill_lo = 1'b0;
        endcase
    end

    // Bit entering at the top position on a right move.
    always_comb begin
        unique case (shift_op_e'(op))
            OP_LSR:  fill_hi = ser_in;
            OP_ROR:  fill_hi = din[0];
            OP_ASR:  fill_hi = din[MSB];
            default: fill_hi = 1'b0;
        endcase
    end

    assign exit_bit = go_right ? din[0] : din[MSB];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_right_nb;
        logic from_left_nb;
        if (i == 0) begin : g_lo
            assign from_right_nb = fill_lo;
        end else begin : g_mid_lo
            assign from_right_nb = din[i-1];
        end
        if (i == MSB) begin : g_hi
            assign from_left_nb = fill_hi;
        end else begin : g_mid_hi
            assign from_left_nb = din[i+1];
        end
        assign result[i] = go_right ? from_left_nb : from_right_nb;
    end

endmodule

// File: rtl/shift_sign_watch.sv
module shift_sign_watch
    import shift_unit_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] din,
    output logic             sign_flip
);
    localparam int MSB = WIDTH - 1;

    // Only a left arithmetic move can reverse the sign of the value.
    always_comb begin
        if (shift_op_e'(op) == OP_ASL) begin
            sign_flip = din[MSB] ^ din[MSB-1];
        end else begin
            sign_flip = 1'b0;
        end
    end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_unit_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic [2:0]       shift_op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             out_bit,
    output logic             ovf
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             gone;
        logic             vs;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [WIDTH-1:0] moved;
    logic             leaving;
    logic             flip;

    shift_datapath #(.WIDTH(WIDTH)) u_path (
        .op       (shift_op),
        .ser_in   (ser_in),
        .din      (din),
        .result   (moved),
        .exit_bit (leaving)
    );

    shift_sign_watch #(.WIDTH(WIDTH)) u_sign (
        .op        (shift_op),
        .din       (din),
        .sign_flip (flip)
    );

    always_comb begin
        st_d = st_q;
        if (shift_en && op_moves(shift_op)) begin
            st_d.word = moved;
            st_d.gone = leaving;
            st_d.vs   = flip;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.word;
    assign out_bit = st_q.gone;
    assign ovf     = st_q.vs;

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             shift_en,
    input logic [2:0]       shift_op,
    input logic             ser_in,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] dout,
    input logic             out_bit,
    input logic             ovf
);
    localparam int MSB = WIDTH - 1;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (dout == '0 && !out_bit && !ovf));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> ($stable(dout) && $stable(out_bit) && $stable(ovf)));

    assert_rotate_keeps_ones_R4: assert property (@(posedge clk) disable iff (rst)
        (shift_en && (shift_op == 3'b010 || shift_op == 3'b011))
        |=> ($countones(dout) == $countones($past(din))));

    assert_sign_flip_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (shift_en && shift_op == 3'b100)
        |=> (ovf == ($past(din[MSB]) ^ $past(din[MSB-1]))));

    assert_asr_sign_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (shift_en && shift_op == 3'b101)
        |=> (dout[MSB] == $past(din[MSB]) && out_bit == $past(din[0])));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (shift_en && shift_op <= 3'b101 && shift_op != 3'b100) |=> !ovf);

    assert_unused_code_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (shift_en && shift_op[2:1] == 2'b11)
        |=> ($stable(dout) && $stable(out_bit) && $stable(ovf)));

    assert_asl_zero_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (shift_en && shift_op == 3'b100) |=> !dout[0]);

endmodule

bind shift_unit shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .shift_op (shift_op),
    .ser_in   (ser_in),
    .din      (din),
    .dout     (dout),
    .out_bit  (out_bit),
    .ovf      (ovf)
);

// File: tb/sim_shift_unit.sv
module sim_shift_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         shift_en = 1'b0;
    logic [2:0]   shift_op = 3'b000;
    logic         ser_in = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         out_bit;
    logic         ovf;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [W-1:0] e_word;
    logic         e_bit;
    logic         e_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_unit #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .shift_en(shift_en), .shift_op(shift_op),
        .ser_in(ser_in), .din(din), .dout(dout), .out_bit(out_bit), .ovf(ovf)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " word"}, dout, e_word);
        check({req, " bit"}, W'(out_bit), W'(e_bit));
        check({req, " ovf"}, W'(ovf), W'(e_ovf));
    endtask

    // Drive at a falling edge, let one rising edge pass, then sample at the next falling edge.
    task automatic step(input logic en, input logic [2:0] op, input logic si, input logic [W-1:0] d);
        @(negedge clk);
        shift_en = en; shift_op = op; ser_in = si; din = d;
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    // Expected result of one strobed operation, from the requirement formulas.
    task automatic expect_op(input logic [2:0] op, input logic si, input logic [W-1:0] d);
        case (op)
            3'b000: begin e_word = {d[W-2:0], si};     e_bit = d[W-1]; e_ovf = 1'b0; end
            3'b001: begin e_word = {si, d[W-1:1]};     e_bit = d[0];   e_ovf = 1'b0; end
            3'b010: begin e_word = {d[W-2:0], d[W-1]}; e_bit = d[W-1]; e_ovf = 1'b0; end
            3'b011: begin e_word = {d[0], d[W-1:1]};   e_bit = d[0];   e_ovf = 1'b0; end
            3'b100: begin e_word = {d[W-2:0], 1'b0};   e_bit = d[W-1]; e_ovf = d[W-1] ^ d[W-2]; end
            3'b101: begin e_word = {d[W-1], d[W-1:1]}; e_bit = d[0];   e_ovf = 1'b0; end
            default: ;
        endcase
    endtask

    task automatic run_op(input string req, input logic [2:0] op, input logic si, input logic [W-1:0] d);
        step(1'b1, op, si, d);
        expect_op(op, si, d);
        check_all(req);
    endtask

    task automatic t_reset_R1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        e_word = '0; e_bit = 1'b0; e_ovf = 1'b0;
        check_all("R1 initial");
        run_op("R1 preload", 3'b100, 1'b0, 8'hC1);
        @(negedge clk);
        rst = 1'b1; shift_en = 1'b1; shift_op = 3'b100; din = 8'h40;
        @(negedge clk);
        rst = 1'b0; shift_en = 1'b0;
        e_word = '0; e_bit = 1'b0; e_ovf = 1'b0;
        check_all("R1 reset over strobe");
    endtask

    task automatic t_logical_R3;
        run_op("R3 lsl ser0", 3'b000, 1'b0, 8'hB4);
        run_op("R3 lsl ser1", 3'b000, 1'b1, 8'hB4);
        run_op("R3 lsr ser0", 3'b001, 1'b0, 8'hB5);
        run_op("R3 lsr ser1", 3'b001, 1'b1, 8'h4A);
    endtask

    task automatic t_rotate_R4_R9;
        run_op("R4 rol", 3'b010, 1'b0, 8'h81);
        run_op("R4 ror", 3'b011, 1'b0, 8'h5A);
        run_op("R9 rol ser1", 3'b010, 1'b1, 8'h3C);
        run_op("R9 ror ser1", 3'b011, 1'b1, 8'h01);
    endtask

    task automatic t_asl_R5;
        run_op("R5 asl 01", 3'b100, 1'b0, 8'h40);
        run_op("R5 asl 00", 3'b100, 1'b0, 8'h20);
        run_op("R5 asl 11", 3'b100, 1'b0, 8'hC0);
        run_op("R5 asl 10", 3'b100, 1'b0, 8'h80);
        run_op("R9 asl ser1", 3'b100, 1'b1, 8'h15);
    endtask

    task automatic t_asr_R6;
        run_op("R6 asr neg", 3'b101, 1'b0, 8'h90);
        run_op("R6 asr pos", 3'b101, 1'b0, 8'h35);
        run_op("R9 asr ser1", 3'b101, 1'b1, 8'h22);
    endtask

    task automatic t_clear_R7;
        for (int c = 0; c < 6; c++) begin
            if (c == 4) continue;
            run_op("R7 set", 3'b100, 1'b0, 8'h7F);
            run_op("R7 cleared", 3'(c), 1'b1, 8'hA6);
        end
    endtask

    task automatic t_hold_R2_R8;
        run_op("R2 setup", 3'b100, 1'b0, 8'h55);
        step(1'b0, 3'b000, 1'b1, 8'hFF);
        check_all("R2 no strobe");
        step(1'b1, 3'b110, 1'b1, 8'h00);
        check_all("R8 code 6");
        step(1'b1, 3'b111, 1'b0, 8'hFF);
        check_all("R8 code 7");
        step(1'b0, 3'b101, 1'b0, 8'h01);
        check_all("R2 no strobe asr");
    endtask

    initial begin
        t_reset_R1();
        t_logical_R3();
        t_rotate_R4_R9();
        t_asl_R5();
        t_asr_R6();
        t_clear_R7();
        t_hold_R2_R8();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule